// File: doc/BRIEF.md
# Interrupt Controller Command Register Interface

This block is the programming front end of an eight-line priority interrupt controller. Software reaches it through two byte-wide addresses and a separate one-byte trigger-mode register. Writes to the command address either restart the setup sequence, set operating modes, or issue end-of-interrupt and priority-rotation commands. Writes to the data address are routed by the setup state machine: they load the vector base, absorb the cascade word, or set the mode flags. Once setup is complete, they load the interrupt mask.

The block holds the mask, the vector base, the rotating priority base and the mode flags. It drives these into the priority arbiter. It reads back the arbiter's in-service and request vectors. It resolves non-specific end-of-interrupt commands against the arbiter's in-service vector and sends the result as a one-hot clear strobe. Poll reads return a word that the arbiter supplies, and the block signals the arbiter to acknowledge that poll.

Top module: `irqc_ctrl_regs`

## Requirements
- R1: After reset every output is 0, and the setup state is idle. In the idle state a data-address write loads the mask.
- R2: A command-address write with bit 4 set restarts setup. It zeroes the mask, vector base, priority base and all mode flags, and pulses `arb_clear` for one cycle. It latches bit 0 as "mode word follows" and bit 1 as "single controller". The trigger-mode register keeps its value.
- R3: The first data write after a restart sets `vec_base` to the data AND 0xF8. The next step is the cascade word if not single. If single, the next step is the mode word when bit 0 of the restart was set, otherwise idle.
- R4: The cascade-word write changes no output. It moves to the mode word if bit 0 of the restart was set, otherwise to idle.
- R5: The mode-word write sets `sfnm` from bit 4 and `aeoi` from bit 1, and returns to idle.
- R6: A data-address read returns the mask, one cycle after the read strobe.
- R7: A command-address write with bit 4 clear and bit 3 set is a mode command. Bit 2 arms poll. When bit 1 is 1, bit 0 loads read-select. When bit 6 is 1, bit 5 loads `special_mask`.
- R8: Other command-address writes decode bits 7:5 as a command code. Codes 0 and 4 load `rot_aeoi` from bit 7.
- R9: Codes 1 and 5 find the in-service line that comes first when scanning upward from `prio_base`, wrapping modulo 8. They pulse that line on `isr_clr`. Code 5 also sets `prio_base` to that line plus one, modulo 8. If `isr_in` is 0, nothing changes.
- R10: Code 3 pulses `isr_clr` for line (data AND 7). Code 7 does the same and also sets `prio_base` to that line plus one, modulo 8.
- R11: Code 6 sets `prio_base` to (data + 1) mod 8. Code 2 changes nothing.
- R12: A command-address read returns `isr_in` when read-select is 1 and `irr_in` when it is 0. Any read while poll is armed instead returns `poll_word_in`, pulses `poll_ack`, and disarms poll.
- R13: A `tm_wr_en` write stores `wdata` AND the parameter `TRIG_WMASK` (default 0xDE) into `trig_mode`. Only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| wr_en | input | 1 | Write strobe for the two main addresses |
| rd_en | input | 1 | Read strobe for the two main addresses |
| addr | input | 1 | 0 = command address, 1 = data address |
| wdata | input | 8 | Write data |
| tm_wr_en | input | 1 | Write strobe for the trigger-mode register |
| isr_in | input | 8 | In-service vector from the arbiter |
| irr_in | input | 8 | Request vector from the arbiter |
| poll_word_in | input | 8 | Poll result word from the arbiter |
| rdata | output | 8 | Registered read data |
| mask | output | 8 | Interrupt mask |
| vec_base | output | 8 | Vector base (low three bits zero) |
| prio_base | output | 3 | Line that holds the highest priority |
| sfnm | output | 1 | Special fully nested mode |
| aeoi | output | 1 | Automatic end-of-interrupt |
| rot_aeoi | output | 1 | Rotate on automatic end-of-interrupt |
| special_mask | output | 1 | Special mask mode |
| isr_clr | output | 8 | One-cycle one-hot in-service clear |
| arb_clear | output | 1 | One-cycle pulse that clears arbiter state on restart |
| poll_ack | output | 1 | One-cycle pulse asking the arbiter to acknowledge the poll |
| trig_mode | output | 8 | Per-line trigger mode (1 = level) |

## Verification
Every result is registered at the clock edge that samples its strobe. Register outputs, `isr_clr`, `arb_clear`, `poll_ack` and `rdata` therefore all become valid one cycle after the strobe and hold until the next edge. The bench drives each access on a falling edge and holds it across exactly one rising edge. At the following falling edge it compares every output against its own model. That check confirms both that the pulses last one cycle and that each register update lands in the expected cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_VEC  = 2'd1,
    ST_CASC = 2'd2,
    ST_MODE = 2'd3
  } setup_step_e;

  // Step after the vector-base word.
  function automatic setup_step_e step_after_vec(input logic single, input logic want_mode);
    if (!single) return ST_CASC;
    return want_mode ? ST_MODE : ST_IDLE;
  endfunction

  // First set line scanning upward from base (modulo 8); {found, line}.
  function automatic logic [3:0] first_line(input logic [7:0] vec, input logic [2:0] base);
    logic [3:0] res;
    logic [2:0] idx;
    res = 4'b0000;
    for (int k = 7; k >= 0; k--) begin
      idx = base + 3'(k);
      if (vec[idx]) res = {1'b1, idx};
    end
    return res;
  endfunction

  function automatic logic [2:0] next_line(input logic [2:0] line);
    return line + 3'd1;
  endfunction

  function automatic logic [7:0] line_bit(input logic [2:0] line);
    return 8'd1 << line;
  endfunction

endpackage

// File: rtl/irqc_setup_seq.sv
module irqc_setup_seq
  import irqc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic          restart,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] vbase_o,
  output logic          sfnm_o,
  output logic          aeoi_o
);
  localparam logic [DW-1:0] VBASE_KEEP = {{(DW-3){1'b1}}, 3'b000};

  setup_step_e step_q;
  logic        single_q, want_mode_q;
  logic        data_wr;

  assign restart = wr_en && !addr && wdata[4];
  assign data_wr = wr_en && addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q      <= ST_IDLE;
      single_q    <= 1'b0;
      want_mode_q <= 1'b0;
      mask_o      <= '0;
      vbase_o     <= '0;
      sfnm_o      <= 1'b0;
      aeoi_o      <= 1'b0;
    end else if (restart) begin
      step_q      <= ST_VEC;
      single_q    <= wdata[1];
      want_mode_q <= wdata[0];
      mask_o      <= '0;
      vbase_o     <= '0;
      sfnm_o      <= 1'b0;
      aeoi_o      <= 1'b0;
    end else if (data_wr) begin
      unique case (step_q)
        ST_IDLE: mask_o <= wdata;
        ST_VEC: begin
          vbase_o <= wdata & VBASE_KEEP;
          step_q  <= step_after_vec(single_q, want_mode_q);
        end
        ST_CASC: step_q <= want_mode_q ? ST_MODE : ST_IDLE;
        ST_MODE: begin
          sfnm_o <= wdata[4];
          aeoi_o <= wdata[1];
          step_q <= ST_IDLE;
        end
        default: step_q <= ST_IDLE;
      endcase
    end
  end

  // R4: the cascade step is reachable only when not single
  a_r4_casc_needs_cascade: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_CASC) |-> !single_q);
  // R6: mask changes only after a data write in the idle step, or a restart
  a_r6_mask_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(data_wr && step_q == ST_IDLE) && !$past(restart) |-> $stable(mask_o));
  // R5: mode flags move only on a mode-word write or a restart
  a_r5_flags_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(data_wr && step_q == ST_MODE) && !$past(restart) |-> $stable({sfnm_o, aeoi_o}));
endmodule

// File: rtl/irqc_cmd_decode.sv
module irqc_cmd_decode
  import irqc_pkg::*;
#(
  parameter int DW = 8,
  localparam int LW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  input  logic          restart,
  input  logic [DW-1:0] isr_in,
  output logic [LW-1:0] prio_base_o,
  output logic          rot_aeoi_o,
  output logic          smask_o,
  output logic          rsel_o,
  output logic          poll_o,
  output logic [DW-1:0] isr_clr_o,
  output logic          arb_clear_o
);
  logic       cmd_wr, mode_wr, op_wr;
  logic [2:0] code;
  logic [3:0] hit;
  logic [2:0] spec_line;

  assign cmd_wr    = wr_en && !addr && !wdata[4];
  assign mode_wr   = cmd_wr && wdata[3];
  assign op_wr     = cmd_wr && !wdata[3];
  assign code      = wdata[7:5];
  assign hit       = first_line(isr_in, prio_base_o);
  assign spec_line = wdata[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_base_o <= '0;
      rot_aeoi_o  <= 1'b0;
      smask_o     <= 1'b0;
      rsel_o      <= 1'b0;
      poll_o      <= 1'b0;
      isr_clr_o   <= '0;
      arb_clear_o <= 1'b0;
    end else begin
      isr_clr_o   <= '0;
      arb_clear_o <= restart;
      if (rd_en) poll_o <= 1'b0;
      if (restart) begin
        prio_base_o <= '0;
        rot_aeoi_o  <= 1'b0;
        smask_o     <= 1'b0;
        rsel_o      <= 1'b0;
        poll_o      <= 1'b0;
      end else if (mode_wr) begin
        if (wdata[2]) poll_o  <= 1'b1;
        if (wdata[1]) rsel_o  <= wdata[0];
        if (wdata[6]) smask_o <= wdata[5];
      end else if (op_wr) begin
        unique case (code)
          3'd0, 3'd4: rot_aeoi_o <= code[2];
          3'd1, 3'd5: if (hit[3]) begin
            isr_clr_o <= line_bit(hit[2:0]);
            if (code[2]) prio_base_o <= next_line(hit[2:0]);
          end
          3'd3: isr_clr_o <= line_bit(spec_line);
          3'd6: prio_base_o <= next_line(spec_line);
          3'd7: begin
            isr_clr_o   <= line_bit(spec_line);
            prio_base_o <= next_line(spec_line);
          end
          default: ;
        endcase
      end
    end
  end

  // R9/R10: at most one in-service line cleared per command
  a_r9_clr_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(isr_clr_o));
  // R9: a non-specific clear targets a line that was in service
  a_r9_clr_was_active: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_wr && (code == 3'd1 || code == 3'd5)) |-> ((isr_clr_o & ~$past(isr_in)) == '0));
  // R11: the priority base moves only after a write
  a_r11_base_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(prio_base_o));
  // R12: a read disarms poll
  a_r12_poll_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !wr_en |=> !poll_o);
endmodule

// File: rtl/irqc_trig_reg.sv
module irqc_trig_reg #(
  parameter int          DW = 8,
  parameter logic [DW-1:0] WMASK = 8'hDE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] value_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  value_o <= '0;
    else if (we) value_o <= wdata & WMASK;
  end

  // R13: value changes only after its own write strobe
  a_r13_tm_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(we) |-> $stable(value_o));
endmodule

// File: rtl/irqc_ctrl_regs.sv
module irqc_ctrl_regs
  import irqc_pkg::*;
#(
  parameter int            DW = 8,
  parameter logic [DW-1:0] TRIG_WMASK = 8'hDE,
  localparam int           LW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  input  logic          tm_wr_en,
  input  logic [DW-1:0] isr_in,
  input  logic [DW-1:0] irr_in,
  input  logic [DW-1:0] poll_word_in,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] mask,
  output logic [DW-1:0] vec_base,
  output logic [LW-1:0] prio_base,
  output logic          sfnm,
  output logic          aeoi,
  output logic          rot_aeoi,
  output logic          special_mask,
  output logic [DW-1:0] isr_clr,
  output logic          arb_clear,
  output logic          poll_ack,
  output logic [DW-1:0] trig_mode
);
  logic restart, rsel, poll_armed;

  irqc_setup_seq #(.DW(DW)) u_setup (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .restart(restart), .mask_o(mask), .vbase_o(vec_base),
    .sfnm_o(sfnm), .aeoi_o(aeoi)
  );

  irqc_cmd_decode #(.DW(DW)) u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .restart(restart), .isr_in(isr_in),
    .prio_base_o(prio_base), .rot_aeoi_o(rot_aeoi), .smask_o(special_mask),
    .rsel_o(rsel), .poll_o(poll_armed), .isr_clr_o(isr_clr), .arb_clear_o(arb_clear)
  );

  irqc_trig_reg #(.DW(DW), .WMASK(TRIG_WMASK)) u_trig (
    .clk(clk), .rst_n(rst_n), .we(tm_wr_en), .wdata(wdata), .value_o(trig_mode)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      poll_ack <= 1'b0;
    end else begin
      poll_ack <= rd_en && poll_armed;
      if (rd_en) begin
        if (poll_armed) rdata <= poll_word_in;
        else if (addr)  rdata <= mask;
        else            rdata <= rsel ? isr_in : irr_in;
      end
    end
  end

  // R2: the arbiter-clear pulse coincides with zeroed mask and priority base
  a_r2_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    arb_clear |-> (mask == '0) && (prio_base == '0) && !sfnm && !aeoi);
  // R12: poll acknowledge is a single-cycle pulse after a read
  a_r12_ack_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    poll_ack |-> $past(rd_en));
endmodule

// File: tb/irqc_ctrl_regs_tb.sv
module irqc_ctrl_regs_tb;
  localparam logic [7:0] TMW = 8'hDE;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, addr = 0, tm_wr_en = 0;
  logic [7:0] wdata = 0, isr_in = 0, irr_in = 0, poll_word_in = 0;
  logic [7:0] rdata, mask, vec_base, isr_clr, trig_mode;
  logic [2:0] prio_base;
  logic sfnm, aeoi, rot_aeoi, special_mask, arb_clear, poll_ack;

  int n_tests = 0, n_fail = 0;

  // model
  int st; // 0 idle,1 vec,2 casc,3 mode
  logic m_single, m_want;
  logic [7:0] e_mask, e_vb, e_clr, e_tm, e_rd;
  logic [2:0] e_pb;
  logic e_sfnm, e_aeoi, e_rot, e_sm, e_rsel, e_poll, e_clear, e_ack;

  irqc_ctrl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .tm_wr_en(tm_wr_en), .isr_in(isr_in), .irr_in(irr_in),
    .poll_word_in(poll_word_in), .rdata(rdata), .mask(mask), .vec_base(vec_base),
    .prio_base(prio_base), .sfnm(sfnm), .aeoi(aeoi), .rot_aeoi(rot_aeoi),
    .special_mask(special_mask), .isr_clr(isr_clr), .arb_clear(arb_clear),
    .poll_ack(poll_ack), .trig_mode(trig_mode)
  );

  always #10 clk = ~clk;

  initial begin
    #4_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    st = 0; m_single = 0; m_want = 0;
    e_mask = 0; e_vb = 0; e_clr = 0; e_tm = 0; e_rd = 0; e_pb = 0;
    e_sfnm = 0; e_aeoi = 0; e_rot = 0; e_sm = 0; e_rsel = 0; e_poll = 0;
    e_clear = 0; e_ack = 0;
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R6 mask"}, mask, e_mask);
    chk({tag, " R3 vec_base"}, vec_base, e_vb);
    chk({tag, " R11 prio_base"}, prio_base, e_pb);
    chk({tag, " R5 flags"}, {sfnm, aeoi}, {e_sfnm, e_aeoi});
    chk({tag, " R8 rot_aeoi"}, rot_aeoi, e_rot);
    chk({tag, " R7 special_mask"}, special_mask, e_sm);
    chk({tag, " R9 isr_clr"}, isr_clr, e_clr);
    chk({tag, " R2 arb_clear"}, arb_clear, e_clear);
    chk({tag, " R12 poll_ack"}, poll_ack, e_ack);
    chk({tag, " R13 trig_mode"}, trig_mode, e_tm);
    chk({tag, " R12 rdata"}, rdata, e_rd);
  endtask

  function automatic logic [3:0] scan_isr(input logic [7:0] v, input logic [2:0] b);
    for (int k = 0; k < 8; k++) begin
      int l;
      l = (b + k) % 8;
      if (v[l]) return {1'b1, 3'(l)};
    end
    return 4'b0;
  endfunction

  task automatic model_write(input logic a, input logic [7:0] d);
    logic [3:0] h;
    if (!a && d[4]) begin
      st = 1; m_want = d[0]; m_single = d[1];
      e_mask = 0; e_vb = 0; e_pb = 0; e_sfnm = 0; e_aeoi = 0;
      e_rot = 0; e_sm = 0; e_rsel = 0; e_poll = 0; e_clear = 1;
    end else if (!a && d[3]) begin
      if (d[2]) e_poll = 1;
      if (d[1]) e_rsel = d[0];
      if (d[6]) e_sm = d[5];
    end else if (!a) begin
      case (d >> 5)
        0: e_rot = 0;
        4: e_rot = 1;
        1, 5: begin
          h = scan_isr(isr_in, e_pb);
          if (h[3]) begin
            e_clr = 8'(1 << h[2:0]);
            if (d[7]) e_pb = 3'((h[2:0] + 1) % 8);
          end
        end
        3: e_clr = 8'(1 << d[2:0]);
        6: e_pb = 3'((d[2:0] + 1) % 8);
        7: begin e_clr = 8'(1 << d[2:0]); e_pb = 3'((d[2:0] + 1) % 8); end
        default: ;
      endcase
    end else begin
      case (st)
        0: e_mask = d;
        1: begin e_vb = {d[7:3], 3'b000}; st = m_single ? (m_want ? 3 : 0) : 2; end
        2: st = m_want ? 3 : 0;
        default: begin e_sfnm = d[4]; e_aeoi = d[1]; st = 0; end
      endcase
    end
  endtask

  task automatic do_wr(input logic a, input logic [7:0] d, input string tag);
    e_clr = 0; e_clear = 0; e_ack = 0;
    model_write(a, d);
    addr = a; wdata = d; wr_en = 1;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
    check_all(tag);
  endtask

  task automatic do_rd(input logic a, input string tag);
    e_clr = 0; e_clear = 0; e_ack = 0;
    if (e_poll) begin e_rd = poll_word_in; e_ack = 1; e_poll = 0; end
    else if (a) e_rd = e_mask;
    else e_rd = e_rsel ? isr_in : irr_in;
    addr = a; rd_en = 1;
    @(posedge clk); @(negedge clk);
    rd_en = 0;
    check_all(tag);
  endtask

  task automatic do_tm(input logic [7:0] d, input string tag);
    e_clr = 0; e_clear = 0; e_ack = 0;
    e_tm = d & TMW;
    wdata = d; tm_wr_en = 1;
    @(posedge clk); @(negedge clk);
    tm_wr_en = 0;
    check_all(tag);
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1 reset");
    // R1: idle after reset, data write is a mask
    do_wr(1, 8'hA5, "R1 mask load");
    do_rd(1, "R6 read mask");
    // R13 trigger mode and survive restart
    do_tm(8'hFF, "R13 tm write");
    // R2/R3/R4/R5 cascaded with mode word
    do_wr(0, 8'h11, "R2 restart casc+mode");
    do_wr(1, 8'h6F, "R3 vec base");
    do_wr(1, 8'h04, "R4 cascade word");
    do_wr(1, 8'h12, "R5 mode word");
    do_wr(1, 8'h3C, "R6 mask after setup");
    // single, no mode word
    do_wr(0, 8'h12, "R2 restart single");
    do_wr(1, 8'hFF, "R3 single vec");
    do_wr(1, 8'h81, "R3 single goes idle");
    // single with mode word
    do_wr(0, 8'h13, "R2 restart single+mode");
    do_wr(1, 8'h47, "R3 vec");
    do_wr(1, 8'h10, "R5 mode word sfnm");
    // cascaded, no mode word
    do_wr(0, 8'h10, "R2 restart casc");
    do_wr(1, 8'h08, "R3 vec");
    do_wr(1, 8'h02, "R4 casc to idle");
    do_wr(1, 8'h55, "R4 mask after casc");
    // R7 mode commands
    do_wr(0, 8'h0B, "R7 rsel=1");
    irr_in = 8'h3A; isr_in = 8'h44;
    do_rd(0, "R12 read isr");
    do_wr(0, 8'h09, "R7 rsel untouched");
    do_rd(0, "R12 still isr");
    do_wr(0, 8'h0A, "R7 rsel=0");
    do_rd(0, "R12 read irr");
    do_wr(0, 8'h68, "R7 smask on");
    do_wr(0, 8'h28, "R7 smask untouched");
    do_wr(0, 8'h48, "R7 smask off");
    do_wr(0, 8'h0C, "R7 poll arm");
    poll_word_in = 8'h85;
    do_rd(1, "R12 poll read");
    do_rd(1, "R12 poll disarmed");
    // R8
    do_wr(0, 8'h80, "R8 rot on");
    do_wr(0, 8'h00, "R8 rot off");
    // R9
    isr_in = 8'h24;
    do_wr(0, 8'h20, "R9 ns eoi");
    do_wr(0, 8'hA0, "R9 rot eoi");
    isr_in = 8'h24;
    do_wr(0, 8'h20, "R9 ns eoi wrap");
    isr_in = 8'h00;
    do_wr(0, 8'hA0, "R9 empty isr");
    // R10 / R11
    do_wr(0, 8'h65, "R10 specific eoi");
    do_wr(0, 8'hE7, "R10 rot specific wrap");
    do_wr(0, 8'hC3, "R11 set prio");
    do_wr(0, 8'h47, "R11 code2 nop");
    // random
    for (int i = 0; i < 600; i++) begin
      int c;
      c = $urandom_range(0, 9);
      isr_in = 8'($urandom); irr_in = 8'($urandom); poll_word_in = 8'($urandom);
      if (c < 5) do_wr(0, 8'($urandom), "R9 rnd cmd");
      else if (c < 8) do_wr(1, 8'($urandom), "R3 rnd data");
      else if (c == 8) do_rd(1'($urandom), "R12 rnd read");
      else do_tm(8'($urandom), "R13 rnd tm");
    end
    // R13: hard reset clears trigger mode
    do_tm(8'hFF, "R13 tm set");
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    model_reset();
    @(negedge clk);
    check_all("R13 after reset");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule